// File: doc/BRIEF.md
# Host Controller Vendor Register Bank

This block is a 32-bit memory-mapped register front end for an SD host controller. It decodes a 4 KB window. Accesses to offsets from 0x200 upward pass untouched to a downstream port that serves the standard slot register set. Lower offsets hit a small local bank of vendor registers, which this block serves itself.

Three local words have side effects on write. Word 0x00 reads a fixed identification value, and bit 0 of a write to it triggers a software reset. That reset clears the whole local bank and sends a one-cycle reset pulse to the slot. Word 0x10 fronts a PHY access port whose acknowledge bit is derived from the request bits in the written value. Word 0x18 holds eMMC control, and its tune-request bit is dropped on every write. Every other word from 0x04 to 0xFC is plain storage. The slot's interrupt line passes straight through.

The bus uses a valid/ready handshake with full-word accesses only. The master holds valid, address, write and data stable until ready is seen at a clock edge. Local accesses complete in the cycle they are presented. Forwarded accesses complete when the slot port raises its ready.

Top module: `hc_vendor_regs`

## Requirements
- R1: An access with bus_addr >= 0x200 raises slot_valid and presents bus_addr, bus_write and bus_wdata unchanged on the slot port. bus_ready follows slot_ready and bus_rdata returns slot_rdata. The local bank is not changed by such an access.
- R2: An access with bus_addr < 0x200 completes in its first cycle: bus_ready is high while bus_valid is high, and slot_valid stays low.
- R3: Offset 0x00 reads 0x00010000 after reset. A write there with bit 0 at 0 leaves the value read unchanged.
- R4: A write to offset 0x00 with bit 0 set clears every local word from 0x04 to 0xFC to zero on that clock edge. Offset 0x00 still reads 0x00010000 afterwards, with bit 0 reading 0.
- R5: slot_reset is high for exactly the one cycle that follows the edge accepting a software-reset write. At all other times it is low, including during rst_n.
- R6: A write to offset 0x10 stores bit 26 as (bit 24 OR bit 25) of the written value. All other bits are stored as written.
- R7: A write to offset 0x18 stores bit 15 as 0. All other bits are stored as written.
- R8: Any other local offset from 0x04 to 0xFC stores the written word and returns it on read.
- R9: Writes to offsets 0x100 to 0x1FC are ignored, and reads there return zero.
- R10: irq equals slot_irq at all times, with no register on the path.
- R11: After rst_n, every local word except offset 0x00 reads zero.
- R12: A local write accepted in the cycle where slot_reset is high is stored normally and is not undone by the software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes at this clock edge |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| slot_valid | output | 1 | Forwarded access request |
| slot_write | output | 1 | Forwarded direction |
| slot_addr | output | 12 | Forwarded byte offset, unchanged |
| slot_wdata | output | 32 | Forwarded write data |
| slot_ready | input | 1 | Slot port completes the access |
| slot_rdata | input | 32 | Slot port read data |
| slot_reset | output | 1 | One-cycle reset pulse to the slot |
| slot_irq | input | 1 | Interrupt from the slot |
| irq | output | 1 | Interrupt out |

## Verification
Two functions can meet in the same cycle. One is the slot reset pulse that follows a software-reset write. The other is the next local write, which the master can present in the very cycle the pulse is high. The bench issues the software reset and then, without an idle cycle, writes a plain storage word. It checks that slot_reset is high before that write and low after it, that the words preloaded earlier read back as zero, and that the word written during the pulse keeps its value.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic [1:0] {
      TGT_LOCAL = 2'd0,
      TGT_HOLE  = 2'd1,
      TGT_SLOT  = 2'd2
   } target_e;
endpackage

// File: rtl/hcv_decode.sv
module hcv_decode
   import hcv_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SLOT_BASE   = 32'h200,
   parameter int unsigned LOCAL_WORDS = 64,
   localparam int unsigned IDX_W      = $clog2(LOCAL_WORDS)
) (
   input  logic [ADDR_W-1:0] addr,
   output target_e           tgt,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(LOCAL_WORDS * 4);

   if (LOCAL_WORDS * 4 > SLOT_BASE) begin : g_bad_span
      $error("local bank overlaps the slot window");
   end
   if (SLOT_BASE >= (1 << ADDR_W)) begin : g_bad_base
      $error("slot base outside the address window");
   end
   if (IDX_W + 2 > ADDR_W) begin : g_bad_idx
      $error("address too narrow for local index");
   end

   assign idx = addr[IDX_W+1:2];

   always_comb begin
      if (addr >= SLOT_A)      tgt = TGT_SLOT;
      else if (addr < SPAN_A)  tgt = TGT_LOCAL;
      else                     tgt = TGT_HOLE;
   end
endmodule

// File: rtl/hcv_wfilter.sv
module hcv_wfilter
   import hcv_pkg::*;
#(
   parameter int unsigned LOCAL_WORDS = 64,
   parameter int unsigned IDX_PHY     = 4,
   parameter int unsigned IDX_TUNE    = 6,
   parameter int unsigned PHY_WR_BIT  = 24,
   parameter int unsigned PHY_RD_BIT  = 25,
   parameter int unsigned PHY_ACK_BIT = 26,
   parameter int unsigned TUNE_BIT    = 15,
   localparam int unsigned IDX_W      = $clog2(LOCAL_WORDS)
) (
   input  logic [IDX_W-1:0] idx,
   input  word_t            wdata,
   output word_t            wdata_f
);
   if (PHY_ACK_BIT >= WORD_W || PHY_WR_BIT >= WORD_W ||
       PHY_RD_BIT >= WORD_W || TUNE_BIT >= WORD_W) begin : g_bad_bit
      $error("side-effect bit outside the word");
   end
   if (IDX_PHY >= LOCAL_WORDS || IDX_TUNE >= LOCAL_WORDS) begin : g_bad_idx
      $error("side-effect register outside the local bank");
   end

   always_comb begin
      wdata_f = wdata;
      if (idx == IDX_W'(IDX_PHY)) begin
         wdata_f[PHY_ACK_BIT] = wdata[PHY_WR_BIT] | wdata[PHY_RD_BIT];
      end else if (idx == IDX_W'(IDX_TUNE)) begin
         wdata_f[TUNE_BIT] = 1'b0;
      end
   end
endmodule

// File: rtl/hcv_regfile.sv
module hcv_regfile
   import hcv_pkg::*;
#(
   parameter int unsigned LOCAL_WORDS = 64,
   parameter int unsigned IDX_FIXED   = 0,
   parameter word_t       POR_VALUE   = 32'h0001_0000,
   localparam int unsigned IDX_W      = $clog2(LOCAL_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  word_t            wdata,
   output word_t            rdata
);
   word_t words [LOCAL_WORDS];

   for (genvar i = 0; i < LOCAL_WORDS; i++) begin : g_word
      if (i == IDX_FIXED) begin : g_fixed
         assign words[i] = POR_VALUE;
      end else begin : g_store
         word_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= '0;
            else if (clear)                     q <= '0;
            else if (we && idx == IDX_W'(i))    q <= wdata;
         end
         assign words[i] = q;
      end
   end

   assign rdata = words[idx];
endmodule

// File: rtl/hc_vendor_regs.sv
module hc_vendor_regs
   import hcv_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SLOT_BASE   = 32'h200,
   parameter int unsigned LOCAL_WORDS = 64,
   parameter word_t       POR_VALUE   = 32'h0001_0000,
   parameter int unsigned IDX_SWR     = 0,
   parameter int unsigned IDX_PHY     = 4,
   parameter int unsigned IDX_TUNE    = 6,
   parameter int unsigned SWR_BIT     = 0,
   parameter int unsigned PHY_WR_BIT  = 24,
   parameter int unsigned PHY_RD_BIT  = 25,
   parameter int unsigned PHY_ACK_BIT = 26,
   parameter int unsigned TUNE_BIT    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ready,
   output logic [31:0]       bus_rdata,
   output logic              slot_valid,
   output logic              slot_write,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [31:0]       slot_wdata,
   input  logic              slot_ready,
   input  logic [31:0]       slot_rdata,
   output logic              slot_reset,
   input  logic              slot_irq,
   output logic              irq
);
   localparam int unsigned IDX_W = $clog2(LOCAL_WORDS);

   if (POR_VALUE[SWR_BIT] != 1'b0) begin : g_bad_por
      $error("reset bit must read back as zero");
   end
   if (IDX_SWR >= LOCAL_WORDS) begin : g_bad_swr
      $error("reset register outside the local bank");
   end

   target_e          tgt;
   logic [IDX_W-1:0] idx;
   word_t            wdata_f;
   word_t            local_rdata;
   logic             local_wr;
   logic             swr_hit;
   logic             reg_we;
   logic             slot_reset_q;

   hcv_decode #(
      .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .LOCAL_WORDS(LOCAL_WORDS)
   ) i_decode (
      .addr(bus_addr), .tgt(tgt), .idx(idx)
   );

   hcv_wfilter #(
      .LOCAL_WORDS(LOCAL_WORDS), .IDX_PHY(IDX_PHY), .IDX_TUNE(IDX_TUNE),
      .PHY_WR_BIT(PHY_WR_BIT), .PHY_RD_BIT(PHY_RD_BIT),
      .PHY_ACK_BIT(PHY_ACK_BIT), .TUNE_BIT(TUNE_BIT)
   ) i_wfilter (
      .idx(idx), .wdata(bus_wdata), .wdata_f(wdata_f)
   );

   // local accesses finish in their first cycle, so valid is the commit strobe
   assign local_wr = bus_valid && bus_write && (tgt == TGT_LOCAL);
   assign swr_hit  = local_wr && (idx == IDX_W'(IDX_SWR)) && bus_wdata[SWR_BIT];
   assign reg_we   = local_wr && (idx != IDX_W'(IDX_SWR));

   hcv_regfile #(
      .LOCAL_WORDS(LOCAL_WORDS), .IDX_FIXED(IDX_SWR), .POR_VALUE(POR_VALUE)
   ) i_regfile (
      .clk(clk), .rst_n(rst_n), .clear(swr_hit), .we(reg_we),
      .idx(idx), .wdata(wdata_f), .rdata(local_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_reset_q <= 1'b0;
      else        slot_reset_q <= swr_hit;
   end
   assign slot_reset = slot_reset_q;

   assign slot_valid = bus_valid && (tgt == TGT_SLOT);
   assign slot_write = bus_write;
   assign slot_addr  = bus_addr;
   assign slot_wdata = bus_wdata;

   always_comb begin
      unique case (tgt)
         TGT_SLOT: begin
            bus_ready = bus_valid && slot_ready;
            bus_rdata = slot_rdata;
         end
         TGT_LOCAL: begin
            bus_ready = bus_valid;
            bus_rdata = local_rdata;
         end
         default: begin
            bus_ready = bus_valid;
            bus_rdata = '0;
         end
      endcase
   end

   assign irq = slot_irq;
endmodule

// File: rtl/hcv_checker.sv
module hcv_checker #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned SLOT_BASE = 32'h200,
   parameter logic [31:0] POR_VALUE = 32'h0001_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ready,
   input logic [31:0]       bus_rdata,
   input logic              slot_valid,
   input logic [ADDR_W-1:0] slot_addr,
   input logic              slot_ready,
   input logic              slot_reset
);
   localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE);

   logic swr_req;
   assign swr_req = bus_valid && bus_ready && bus_write &&
                    (bus_addr == '0) && bus_wdata[0];

   // R2
   local_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr < SLOT_A) |-> (bus_ready && !slot_valid));

   // R1
   fwd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr >= SLOT_A) |->
         (slot_valid && slot_addr == bus_addr && bus_ready == slot_ready));

   // R5
   swr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swr_req |=> slot_reset);

   // R5
   swr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_reset |-> $past(swr_req));

   // R3
   por_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == '0) |-> (bus_rdata == POR_VALUE));
endmodule

bind hc_vendor_regs hcv_checker #(
   .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .POR_VALUE(POR_VALUE)
) i_hcv_checker (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
   .bus_rdata(bus_rdata), .slot_valid(slot_valid), .slot_addr(slot_addr),
   .slot_ready(slot_ready), .slot_reset(slot_reset)
);

// File: tb/test_hc_vendor_regs.sv
module test_hc_vendor_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        slot_valid;
   logic        slot_write;
   logic [11:0] slot_addr;
   logic [31:0] slot_wdata;
   logic        slot_ready = 1'b0;
   logic [31:0] slot_rdata;
   logic        slot_reset;
   logic        slot_irq = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // downstream slot model: read data derived from the address
   assign slot_rdata = {20'hC0DE5, slot_addr};

   hc_vendor_regs i_hc_vendor_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
      .bus_rdata(bus_rdata), .slot_valid(slot_valid), .slot_write(slot_write),
      .slot_addr(slot_addr), .slot_wdata(slot_wdata), .slot_ready(slot_ready),
      .slot_rdata(slot_rdata), .slot_reset(slot_reset), .slot_irq(slot_irq),
      .irq(irq)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d, output logic rdy,
                     output logic sv);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata; rdy = bus_ready; sv = slot_valid;
      @(posedge clk);
      #1 bus_valid = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
      logic [31:0] d; logic rdy; logic sv;
      rd(a, d, rdy, sv);
      check(tag, d, exp);
   endtask

   task automatic t_reset_state();
      logic [31:0] d; logic rdy; logic sv;
      check("R5 slot_reset low in reset", {31'd0, slot_reset}, 32'd0);
      rd(12'h000, d, rdy, sv);
      check("R3 por value", d, 32'h0001_0000);
      check("R2 local ready", {31'd0, rdy}, 32'd1);
      check("R2 no slot_valid", {31'd0, sv}, 32'd0);
      rd_chk("R11 phy word zero", 12'h010, 32'd0);
      rd_chk("R11 tune word zero", 12'h018, 32'd0);
      rd_chk("R11 word 0x04 zero", 12'h004, 32'd0);
      rd_chk("R11 word 0xFC zero", 12'h0FC, 32'd0);
   endtask

   task automatic t_plain();
      wr(12'h004, 32'hDEAD_BEEF);
      wr(12'h0FC, 32'h1234_5678);
      wr(12'h008, 32'h0000_8000);
      rd_chk("R8 word 0x04", 12'h004, 32'hDEAD_BEEF);
      rd_chk("R8 word 0xFC", 12'h0FC, 32'h1234_5678);
      rd_chk("R8 word 0x08 bit15 kept", 12'h008, 32'h0000_8000);
   endtask

   task automatic t_phy();
      wr(12'h010, 32'h0100_0000);
      rd_chk("R6 write req sets ack", 12'h010, 32'h0500_0000);
      wr(12'h010, 32'h0200_00FF);
      rd_chk("R6 read req sets ack", 12'h010, 32'h0600_00FF);
      wr(12'h010, 32'h0400_1234);
      rd_chk("R6 no req clears ack", 12'h010, 32'h0000_1234);
      wr(12'h010, 32'hFFFF_FFFF);
      rd_chk("R6 both req", 12'h010, 32'hFFFF_FFFF);
   endtask

   task automatic t_tune();
      wr(12'h018, 32'hFFFF_FFFF);
      rd_chk("R7 tune dropped all ones", 12'h018, 32'hFFFF_7FFF);
      wr(12'h018, 32'h0000_8001);
      rd_chk("R7 tune dropped", 12'h018, 32'h0000_0001);
   endtask

   task automatic t_por_nonreset();
      wr(12'h000, 32'hFFFF_FFFE);
      check("R5 no pulse without bit0", {31'd0, slot_reset}, 32'd0);
      rd_chk("R3 word 0 unchanged", 12'h000, 32'h0001_0000);
      rd_chk("R3 other words kept", 12'h004, 32'hDEAD_BEEF);
   endtask

   task automatic t_hole();
      logic [31:0] d; logic rdy; logic sv;
      wr(12'h100, 32'hAAAA_5555);
      wr(12'h1FC, 32'h5555_AAAA);
      rd(12'h100, d, rdy, sv);
      check("R9 hole 0x100 reads zero", d, 32'd0);
      check("R9 hole no slot access", {31'd0, sv}, 32'd0);
      rd_chk("R9 hole 0x1FC reads zero", 12'h1FC, 32'd0);
      rd_chk("R9 word 0x00 unaliased", 12'h000, 32'h0001_0000);
      rd_chk("R9 word 0xFC unaliased", 12'h0FC, 32'h1234_5678);
   endtask

   task automatic t_swr_overlap();
      wr(12'h010, 32'h0100_0001);
      wr(12'h018, 32'h0000_0042);
      wr(12'h000, 32'h0000_0001);
      check("R5 pulse after swr", {31'd0, slot_reset}, 32'd1);
      wr(12'h008, 32'h0000_00A5);
      check("R5 pulse one cycle", {31'd0, slot_reset}, 32'd0);
      rd_chk("R4 word 0x04 cleared", 12'h004, 32'd0);
      rd_chk("R4 phy cleared", 12'h010, 32'd0);
      rd_chk("R4 tune cleared", 12'h018, 32'd0);
      rd_chk("R4 word 0xFC cleared", 12'h0FC, 32'd0);
      rd_chk("R4 word 0 still por", 12'h000, 32'h0001_0000);
      rd_chk("R12 write during pulse kept", 12'h008, 32'h0000_00A5);
      check("R5 stays low", {31'd0, slot_reset}, 32'd0);
   endtask

   task automatic t_forward();
      wr(12'h004, 32'h0000_1111);
      @(negedge clk);
      slot_ready = 1'b0;
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h234;
      #1;
      check("R1 slot_valid", {31'd0, slot_valid}, 32'd1);
      check("R1 slot_addr", {20'd0, slot_addr}, 32'h234);
      check("R1 stall while slot busy", {31'd0, bus_ready}, 32'd0);
      @(negedge clk);
      check("R1 still stalled", {31'd0, bus_ready}, 32'd0);
      slot_ready = 1'b1;
      #1;
      check("R1 ready follows slot", {31'd0, bus_ready}, 32'd1);
      check("R1 read data from slot", bus_rdata, 32'hC0DE_5234);
      @(posedge clk);
      #1 bus_valid = 1'b0; slot_ready = 1'b0;
      @(negedge clk);
      slot_ready = 1'b1;
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h204; bus_wdata = 32'h7777_0000;
      #1;
      check("R1 slot_write", {31'd0, slot_write}, 32'd1);
      check("R1 slot_wdata", slot_wdata, 32'h7777_0000);
      check("R1 slot_addr write", {20'd0, slot_addr}, 32'h204);
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_write = 1'b0; slot_ready = 1'b0;
      rd_chk("R1 local word untouched", 12'h004, 32'h0000_1111);
      wr(12'h200, 32'h0000_0001);
      check("R1 forwarded bit0 no pulse", {31'd0, slot_reset}, 32'd0);
   endtask

   task automatic t_irq();
      @(negedge clk);
      slot_irq = 1'b1;
      #1 check("R10 irq high", {31'd0, irq}, 32'd1);
      slot_irq = 1'b0;
      #1 check("R10 irq low", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R5 slot_reset low during rst_n", {31'd0, slot_reset}, 32'd0);
      rst_n = 1'b1;
      t_reset_state();
      t_plain();
      t_phy();
      t_tune();
      t_por_nonreset();
      t_hole();
      t_swr_overlap();
      t_forward();
      t_irq();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule